// File: doc/BRIEF.md
# Watchdog Supervisor with Automatic Keep-Alive

This block is a system watchdog. Its expiry counter never stops. It restarts from zero on every kick. If the counter reaches its timeout window without a kick, the block drives a registered, active-low system reset pulse of fixed width. Software picks one of two modes with a pair of single-cycle controls.

In the passive mode, an internal free-running generator supplies kicks at a period shorter than the timeout, so the counter never expires. In the armed mode, the internal kicks are ignored and only the software kick input restarts the counter. A static strap input gates the reset output. While the strap is low, no reset can be issued, and a pulse already in progress is cut short.

All time constants are parameters in clock cycles. A real build sets them from the clock rate: a 1 s timeout, a 0.5 s keep-alive period and a pulse of at least 200 us. A simulation build can use small values.

Top module: `wdog_supervisor`

## Requirements
- R1: After `rst_ni` is released, `wdt_rst_no` is high and the mode is passive. With the strap high and no software action, no reset pulse follows.
- R2: In armed mode with the strap high, `wdt_rst_no` goes low exactly `TIMEOUT_CYC` clock edges after the last edge at which a kick was sampled, if no kick is sampled in between.
- R3: While `strap_i` is low, `wdt_rst_no` is high from the next edge on. Dropping the strap during a pulse ends the pulse at the next edge.
- R4: In passive mode the internal generator kicks every `AUTOKICK_CYC` cycles, with `AUTOKICK_CYC < TIMEOUT_CYC`, so no reset is issued however long software stays silent.
- R5: Each sampled `kick_i` pulse restarts the counter from zero. In armed mode, kicks spaced fewer than `TIMEOUT_CYC` cycles apart prevent any reset, and wider spacing causes one.
- R6: A reset pulse keeps `wdt_rst_no` low for exactly `PULSE_CYC` consecutive cycles, provided the strap stays high.
- R7: `arm_i` selects armed mode and `disarm_i` selects passive mode, each from the next edge. When both are high in the same cycle, passive mode wins.
- R8: A kick sampled on the same edge at which the counter would expire wins. No pulse starts, and the counter restarts from zero.
- R9: When a pulse completes, the mode returns to passive and the counter restarts from zero. No further pulse occurs without a new `arm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | Single-cycle pulse: select armed mode |
| disarm_i | input | 1 | Single-cycle pulse: select passive mode (priority) |
| kick_i | input | 1 | Single-cycle software kick |
| strap_i | input | 1 | Static output enable; low blocks the reset output |
| wdt_rst_no | output | 1 | Registered active-low system reset pulse |

## Verification
The bench measures the exact distance from the last kick to the falling edge, and the exact pulse width. A counter off by one on either boundary shows up as a pulse one cycle early or late. A kick placed on the expiry edge catches a design that lets the timeout win. Such a design would pulse where none is expected, and it would not restart the window from that kick.

Further runs show the following faults:
- If the strap does not gate the output, the pulse appears with the strap low.
- If the strap does not abort a pulse in progress, the output stays low after the strap drops.
- If the mode does not fall back to passive after a pulse, a second pulse follows one timeout later.
- If passive mode wins the wrong way on simultaneous controls, the block is left armed.

// File: rtl/wdog_sup_pkg.sv
package wdog_sup_pkg;

   typedef enum logic {
      WD_PASSIVE = 1'b0,
      WD_ARMED   = 1'b1
   } wd_mode_e;

   // Counter width able to hold values 0 .. n-1
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
   import wdog_sup_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     set_arm_i,
   input  logic     set_safe_i,
   input  logic     force_safe_i,
   output wd_mode_e mode_o
);

   wd_mode_e mode_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= WD_PASSIVE;
      end else if (set_safe_i || force_safe_i) begin
         mode_q <= WD_PASSIVE;
      end else if (set_arm_i) begin
         mode_q <= WD_ARMED;
      end
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/wdog_autokick.sv
module wdog_autokick
   import wdog_sup_pkg::*;
#(
   parameter int unsigned PERIOD = 25_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);

   localparam int unsigned W = cnt_width(PERIOD);
   localparam logic [W-1:0] LAST = W'(PERIOD - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/wdog_window.sv
module wdog_window
   import wdog_sup_pkg::*;
#(
   parameter int unsigned TIMEOUT = 50_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic kick_i,
   input  logic hold_i,
   output logic expire_o
);

   localparam int unsigned W = cnt_width(TIMEOUT);
   localparam logic [W-1:0] LAST = W'(TIMEOUT - 1);

   logic [W-1:0] cnt_q;
   logic         at_last;

   assign at_last  = (cnt_q == LAST);
   // a kick on the expiry edge takes precedence
   assign expire_o = at_last && !kick_i && !hold_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (kick_i || hold_i || at_last) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
   import wdog_sup_pkg::*;
#(
   parameter int unsigned WIDTH_CYC = 10_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fire_i,
   input  logic strap_i,
   output logic active_o,
   output logic done_o
);

   logic active_q;

   generate
      if (WIDTH_CYC == 1) begin : g_single
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               active_q <= 1'b0;
            end else begin
               active_q <= fire_i && strap_i && !active_q;
            end
         end
         assign done_o = active_q && strap_i;
      end else begin : g_count
         localparam int unsigned W = cnt_width(WIDTH_CYC);
         localparam logic [W-1:0] LOAD = W'(WIDTH_CYC - 1);
         logic [W-1:0] left_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               active_q <= 1'b0;
               left_q   <= '0;
            end else if (!strap_i) begin
               active_q <= 1'b0;
               left_q   <= '0;
            end else if (active_q) begin
               if (left_q == '0) begin
                  active_q <= 1'b0;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end else if (fire_i) begin
               active_q <= 1'b1;
               left_q   <= LOAD;
            end
         end
         assign done_o = active_q && strap_i && (left_q == '0);
      end
   endgenerate

   assign active_o = active_q;

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
   import wdog_sup_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC  = 50_000_000,
   parameter int unsigned AUTOKICK_CYC = 25_000_000,
   parameter int unsigned PULSE_CYC    = 10_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic disarm_i,
   input  logic kick_i,
   input  logic strap_i,
   output logic wdt_rst_no
);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (AUTOKICK_CYC < 1 || AUTOKICK_CYC >= TIMEOUT_CYC) begin : g_bad_autokick
         $error("AUTOKICK_CYC must be in 1 .. TIMEOUT_CYC-1");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("PULSE_CYC must be at least 1");
      end
   endgenerate

   wd_mode_e mode;
   logic     mode_armed;
   logic     auto_tick;
   logic     kick_any;
   logic     expire;
   logic     fire;
   logic     pulse_active;
   logic     pulse_done;

   assign mode_armed = (mode == WD_ARMED);
   assign kick_any   = kick_i || (auto_tick && !mode_armed);
   assign fire       = expire && mode_armed && strap_i;

   wdog_mode_reg u_mode (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .set_arm_i    (arm_i),
      .set_safe_i   (disarm_i),
      .force_safe_i (pulse_done),
      .mode_o       (mode)
   );

   wdog_autokick #(.PERIOD(AUTOKICK_CYC)) u_auto (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (auto_tick)
   );

   wdog_window #(.TIMEOUT(TIMEOUT_CYC)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .kick_i   (kick_any),
      .hold_i   (pulse_active),
      .expire_o (expire)
   );

   wdog_pulse #(.WIDTH_CYC(PULSE_CYC)) u_pulse (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fire_i   (fire),
      .strap_i  (strap_i),
      .active_o (pulse_active),
      .done_o   (pulse_done)
   );

   // driven straight from the pulse flop
   assign wdt_rst_no = !pulse_active;

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
   parameter int unsigned PULSE_CYC = 10_000
) (
   input logic clk_i,
   input logic rst_ni,
   input logic arm_i,
   input logic disarm_i,
   input logic kick_i,
   input logic strap_i,
   input logic mode_armed,
   input logic wdt_rst_no
);

   int unsigned low_run;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || wdt_rst_no) low_run <= 0;
      else                       low_run <= low_run + 1;
   end

   // R3
   a_r3_strap_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strap_i |=> wdt_rst_no);

   // R2
   a_r2_fire_needs_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wdt_rst_no) |-> ($past(mode_armed) && $past(strap_i)));

   // R4
   a_r4_passive_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_armed && wdt_rst_no) |=> wdt_rst_no);

   // R8
   a_r8_kick_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kick_i && wdt_rst_no) |=> wdt_rst_no);

   // R6
   a_r6_full_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(wdt_rst_no) && $past(strap_i)) |-> (low_run >= PULSE_CYC));

   // R9
   a_r9_back_to_passive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(wdt_rst_no) && $past(strap_i)) |-> !mode_armed);

   // R7
   a_r7_disarm_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disarm_i |=> !mode_armed);

   a_r7_arm_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && !disarm_i && wdt_rst_no) |=> mode_armed);

endmodule

bind wdog_supervisor wdog_supervisor_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .arm_i      (arm_i),
   .disarm_i   (disarm_i),
   .kick_i     (kick_i),
   .strap_i    (strap_i),
   .mode_armed (mode_armed),
   .wdt_rst_no (wdt_rst_no)
);

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb_top;

   localparam int unsigned T  = 40;
   localparam int unsigned AK = 20;
   localparam int unsigned P  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, disarm = 1'b0, kick = 1'b0, strap = 1'b0;
   logic rst_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   wdog_supervisor #(.TIMEOUT_CYC(T), .AUTOKICK_CYC(AK), .PULSE_CYC(P)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .arm_i      (arm),
      .disarm_i   (disarm),
      .kick_i     (kick),
      .strap_i    (strap),
      .wdt_rst_no (rst_out)
   );

   typedef struct packed {
      logic        strap;
      logic        armed;
      logic [15:0] gap;
      logic [15:0] cycles;
      logic        fire;
   } vec_t;

   // strap, armed, kick spacing (0 = none), run length, pulse expected
   localparam vec_t VECS [8] = '{
      '{1'b1, 1'b0, 16'd0,  16'd200, 1'b0},   // R4
      '{1'b1, 1'b1, 16'd0,  16'd200, 1'b1},   // R2
      '{1'b1, 1'b1, 16'd30, 16'd200, 1'b0},   // R5
      '{1'b1, 1'b1, 16'd39, 16'd200, 1'b0},   // R5
      '{1'b0, 1'b1, 16'd0,  16'd200, 1'b0},   // R3
      '{1'b0, 1'b0, 16'd0,  16'd200, 1'b0},   // R3
      '{1'b1, 1'b1, 16'd60, 16'd200, 1'b1},   // R5
      '{1'b1, 1'b0, 16'd60, 16'd200, 1'b0}    // R4
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; arm = 1'b0; disarm = 1'b0; kick = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_arm();
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic pulse_kick();
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   // returns 1 if the output went low within n cycles
   task automatic watch(input int n, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!rst_out) seen = 1'b1;
      end
   endtask

   initial begin
      bit seen;
      strap = 1'b1;
      // R1: reset state
      repeat (2) @(negedge clk);
      check(rst_out === 1'b1, "R1 output high in reset", rst_out, 1);
      do_reset();
      check(rst_out === 1'b1, "R1 output high after reset", rst_out, 1);
      watch(3 * T, seen);
      check(!seen, "R1 passive after reset, no pulse", seen, 0);

      // vector table
      for (int v = 0; v < 8; v++) begin
         do_reset();
         strap = VECS[v].strap;
         if (VECS[v].armed) pulse_arm();
         seen = 1'b0;
         for (int i = 0; i < int'(VECS[v].cycles); i++) begin
            kick = (VECS[v].gap != 0) && (i % int'(VECS[v].gap) == 0);
            @(negedge clk);
            if (!rst_out) seen = 1'b1;
         end
         kick = 1'b0;
         check(seen == VECS[v].fire, $sformatf("R2/R3/R4/R5 vector %0d pulse seen", v),
               seen, VECS[v].fire);
      end

      // R2 exact timing, R6 exact width, R9 passive afterwards
      strap = 1'b1;
      do_reset();
      pulse_arm();
      pulse_kick();
      repeat (T - 1) @(negedge clk);
      check(rst_out === 1'b1, "R2 still high one cycle before timeout", rst_out, 1);
      @(negedge clk);
      check(rst_out === 1'b0, "R2 low at timeout", rst_out, 0);
      repeat (P - 1) @(negedge clk);
      check(rst_out === 1'b0, "R6 low through last pulse cycle", rst_out, 0);
      @(negedge clk);
      check(rst_out === 1'b1, "R6 high after PULSE_CYC cycles", rst_out, 1);
      watch(3 * T, seen);
      check(!seen, "R9 no second pulse after completion", seen, 0);

      // R8 kick on the expiry edge wins, R5 window restarts from that kick
      do_reset();
      pulse_arm();
      pulse_kick();
      repeat (T - 1) @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      check(rst_out === 1'b1, "R8 kick on expiry edge, no pulse", rst_out, 1);
      repeat (T - 1) @(negedge clk);
      check(rst_out === 1'b1, "R5 window restarted by kick, still high", rst_out, 1);
      @(negedge clk);
      check(rst_out === 1'b0, "R5 pulse TIMEOUT_CYC after restart", rst_out, 0);

      // R3 strap drop aborts a pulse in progress
      do_reset();
      pulse_arm();
      pulse_kick();
      repeat (T) @(negedge clk);
      check(rst_out === 1'b0, "R3 pulse started before strap drop", rst_out, 0);
      strap = 1'b0;
      @(negedge clk);
      check(rst_out === 1'b1, "R3 strap drop ends pulse", rst_out, 1);
      watch(2 * T, seen);
      check(!seen, "R3 stays high with strap low", seen, 0);
      strap = 1'b1;

      // R7 simultaneous controls: passive wins
      do_reset();
      arm = 1'b1; disarm = 1'b1;
      @(negedge clk);
      arm = 1'b0; disarm = 1'b0;
      watch(3 * T, seen);
      check(!seen, "R7 both controls give passive", seen, 0);

      // R7 arm then disarm returns to passive
      do_reset();
      pulse_arm();
      disarm = 1'b1;
      @(negedge clk);
      disarm = 1'b0;
      watch(3 * T, seen);
      check(!seen, "R7 disarm leaves armed mode", seen, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100_000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule